// File: doc/BRIEF.md
# Debug Register Access Arbiter

This block rules on a single system-register read or write aimed at a debug register. From the privilege level of the access and a bundle of status and trap-control inputs, it picks one of five outcomes: perform the access, refuse it as undefined, trap to level 2, trap to level 3, or halt the core for the external debugger. The inputs cover which higher levels exist or are enabled, the halted state, secure debug disable, a monitor trap bit, two hypervisor trap bits, separate fine-grained read and write trap bits, the OS lock and halting permission.

Each privilege level applies its own fixed list of checks, and the first check that matches decides the outcome. The inputs are captured on a request strobe. The outcome, a one-hot vector, and the exception syndrome class appear one clock later, marked by a one-cycle valid pulse. The register storage and the exception entry are handled elsewhere.

Top module: `dbg_access_gate`

## Requirements
- R1: An access at level 0 (`cur_level` = 0) always gives undefined.
- R2: At level 1, undefined is the first choice when `halted`, `has_l3`, `sec_dbg_off`, `l3_prio_opt` and `mon_trap` are all set. This choice ranks above the level-2 traps.
- R3: At level 1, the next check traps to level 2 when `l2_active` is set, fine-grained trapping is allowed (`has_l3` clear or `l3_fg_en` set), and the fine-grained bit for this direction is set. A read uses `fg_rd_trap` and a write (`req_write` = 1) uses `fg_wr_trap`. The other direction's bit has no effect.
- R4: At level 1, the next check traps to level 2 when `l2_active` is set and `hyp_trap_all` or `hyp_trap_dbg` is set.
- R5: At levels 1 and 2, when the earlier checks do not match and both `has_l3` and `mon_trap` are set, the outcome is undefined if `halted` and `sec_dbg_off` are both set, and a trap to level 3 otherwise.
- R6: At levels 1, 2 and 3, when the earlier checks do not match and `os_lock` is clear, `halt_ok` is set and `ext_trap` is set, the outcome is a debug halt. Otherwise the access is performed.
- R7: At level 2 no trap to level 2 is ever produced, whatever the level-2 trap bits are. At level 3 only the halt check applies, and every other input has no effect.
- R8: `rsp_class` is 0x18 with every trap to level 2 or level 3. It is 0 with every other outcome and when no response is shown.
- R9: `rsp_outcome` is one-hot on every response, with bit 0 perform, bit 1 undefined, bit 2 trap to level 2, bit 3 trap to level 3 and bit 4 debug halt.
- R10: A request with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle only. In cycles with no response, and after reset, `rsp_valid`, `rsp_outcome` and `rsp_class` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled while it is high |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| cur_level | input | 2 | Privilege level of the access, 0 to 3 |
| has_l3 | input | 1 | Level 3 is implemented |
| l2_active | input | 1 | Level 2 is enabled for the current state |
| halted | input | 1 | Core is in debug halt |
| sec_dbg_off | input | 1 | Secure debug is disabled |
| l3_prio_opt | input | 1 | Implementation option that gives the halted monitor-trap undefined the top priority |
| mon_trap | input | 1 | Monitor debug-register trap bit |
| l3_fg_en | input | 1 | Level 3 allows fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained trap bit for reads of this register |
| fg_wr_trap | input | 1 | Fine-grained trap bit for writes of this register |
| hyp_trap_all | input | 1 | Hypervisor trap-all-debug bit |
| hyp_trap_dbg | input | 1 | Hypervisor debug-register trap bit |
| os_lock | input | 1 | OS lock is set |
| halt_ok | input | 1 | Halting is currently allowed |
| ext_trap | input | 1 | External debugger asks to trap software accesses |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_outcome | output | 5 | One-hot outcome |
| rsp_class | output | 6 | Exception syndrome class |

## Verification
The assertions assume that each input holds one fixed value for the whole clock cycle in which `req_valid` is high. They also assume that `cur_level` is always a defined 2-bit value, so all four levels are meaningful. The bench changes every input only at the falling clock edge, and it draws `cur_level` only from 0 to 3. Directed requests cover each priority boundary. Pseudo-random requests, sent back to back and with idle gaps between them, cover the rest of the input space.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    localparam int OUT_W      = 5;
    localparam int OUT_PERF   = 0;
    localparam int OUT_UNDEF  = 1;
    localparam int OUT_TRAP2  = 2;
    localparam int OUT_TRAP3  = 3;
    localparam int OUT_HALT   = 4;

    typedef logic [OUT_W-1:0] outcome_t;

    typedef struct packed {
        logic     hit;
        outcome_t res;
    } verdict_t;

    function automatic outcome_t one_of(input int idx);
        outcome_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // first matching verdict wins
    function automatic verdict_t first_hit(input verdict_t a, input verdict_t b);
        return a.hit ? a : b;
    endfunction

    function automatic logic is_trap(input outcome_t o);
        return o[OUT_TRAP2] | o[OUT_TRAP3];
    endfunction

endpackage

// File: rtl/dbgacc_mon_stage.sv
module dbgacc_mon_stage
    import dbgacc_pkg::*;
(
    input  logic     has_l3,
    input  logic     halted,
    input  logic     sec_dbg_off,
    input  logic     l3_prio_opt,
    input  logic     mon_trap,
    output verdict_t early_v,
    output verdict_t mon_v
);
    logic mon_armed;
    logic locked_halt;

    always_comb begin
        mon_armed   = has_l3 & mon_trap;
        locked_halt = halted & sec_dbg_off;

        early_v.hit = mon_armed & locked_halt & l3_prio_opt;
        early_v.res = one_of(OUT_UNDEF);

        mon_v.hit   = mon_armed;
        mon_v.res   = locked_halt ? one_of(OUT_UNDEF) : one_of(OUT_TRAP3);
    end

    always_comb begin
        AST_EARLY_IMPLIES_MON: assert (!early_v.hit || (mon_v.hit && mon_v.res[OUT_UNDEF])); // R2
    end
endmodule

// File: rtl/dbgacc_hyp_stage.sv
module dbgacc_hyp_stage
    import dbgacc_pkg::*;
(
    input  logic     req_write,
    input  logic     has_l3,
    input  logic     l2_active,
    input  logic     l3_fg_en,
    input  logic     fg_rd_trap,
    input  logic     fg_wr_trap,
    input  logic     hyp_trap_all,
    input  logic     hyp_trap_dbg,
    output verdict_t fg_v,
    output verdict_t hyp_v
);
    logic fg_allowed;
    logic fg_bit;

    always_comb begin
        fg_allowed = ~has_l3 | l3_fg_en;
        fg_bit     = req_write ? fg_wr_trap : fg_rd_trap;

        fg_v.hit   = l2_active & fg_allowed & fg_bit;
        fg_v.res   = one_of(OUT_TRAP2);

        hyp_v.hit  = l2_active & (hyp_trap_all | hyp_trap_dbg);
        hyp_v.res  = one_of(OUT_TRAP2);
    end

    always_comb begin
        AST_L2TRAP_NEEDS_L2: assert (l2_active || !(fg_v.hit || hyp_v.hit)); // R3
    end
endmodule

// File: rtl/dbgacc_halt_stage.sv
module dbgacc_halt_stage
    import dbgacc_pkg::*;
(
    input  logic     os_lock,
    input  logic     halt_ok,
    input  logic     ext_trap,
    output verdict_t halt_v,
    output verdict_t perf_v
);
    always_comb begin
        halt_v.hit = ~os_lock & halt_ok & ext_trap;
        halt_v.res = one_of(OUT_HALT);
        perf_v.hit = 1'b1;
        perf_v.res = one_of(OUT_PERF);
    end
endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
    import dbgacc_pkg::*;
#(
    parameter int              CLASS_W    = 6,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         cur_level,
    input  logic               has_l3,
    input  logic               l2_active,
    input  logic               halted,
    input  logic               sec_dbg_off,
    input  logic               l3_prio_opt,
    input  logic               mon_trap,
    input  logic               l3_fg_en,
    input  logic               fg_rd_trap,
    input  logic               fg_wr_trap,
    input  logic               hyp_trap_all,
    input  logic               hyp_trap_dbg,
    input  logic               os_lock,
    input  logic               halt_ok,
    input  logic               ext_trap,
    output logic               rsp_valid,
    output logic [OUT_W-1:0]   rsp_outcome,
    output logic [CLASS_W-1:0] rsp_class
);
    verdict_t early_v, mon_v, fg_v, hyp_v, halt_v, perf_v;
    verdict_t final_v;
    lvl_e     lvl;

    dbgacc_mon_stage u_mon (
        .has_l3      (has_l3),
        .halted      (halted),
        .sec_dbg_off (sec_dbg_off),
        .l3_prio_opt (l3_prio_opt),
        .mon_trap    (mon_trap),
        .early_v     (early_v),
        .mon_v       (mon_v)
    );

    dbgacc_hyp_stage u_hyp (
        .req_write    (req_write),
        .has_l3       (has_l3),
        .l2_active    (l2_active),
        .l3_fg_en     (l3_fg_en),
        .fg_rd_trap   (fg_rd_trap),
        .fg_wr_trap   (fg_wr_trap),
        .hyp_trap_all (hyp_trap_all),
        .hyp_trap_dbg (hyp_trap_dbg),
        .fg_v         (fg_v),
        .hyp_v        (hyp_v)
    );

    dbgacc_halt_stage u_halt (
        .os_lock  (os_lock),
        .halt_ok  (halt_ok),
        .ext_trap (ext_trap),
        .halt_v   (halt_v),
        .perf_v   (perf_v)
    );

    // Per-level priority chains. At level 2 the early undefined check is
    // omitted: the monitor check below it yields the same undefined result.
    always_comb begin
        lvl = lvl_e'(cur_level);
        unique case (lvl)
            LVL0: begin
                final_v.hit = 1'b1;
                final_v.res = one_of(OUT_UNDEF);
            end
            LVL1: final_v = first_hit(early_v, first_hit(fg_v, first_hit(hyp_v,
                            first_hit(mon_v, first_hit(halt_v, perf_v)))));
            LVL2: final_v = first_hit(mon_v, first_hit(halt_v, perf_v));
            default: final_v = first_hit(halt_v, perf_v);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_outcome <= '0;
            rsp_class   <= '0;
        end else if (req_valid) begin
            rsp_valid   <= 1'b1;
            rsp_outcome <= final_v.res;
            rsp_class   <= is_trap(final_v.res) ? TRAP_CLASS : '0;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_outcome <= '0;
            rsp_class   <= '0;
        end
    end

    AST_ONEHOT_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones(rsp_outcome) == 1); // R9

    AST_PULSE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_outcome == '0 && rsp_class == '0)); // R10

    AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd0) |=> rsp_outcome[OUT_UNDEF]); // R1

    AST_L2_NO_L2TRAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd2) |=> !rsp_outcome[OUT_TRAP2]); // R7

    AST_L3_HALT_OR_PERF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd3) |=> (rsp_outcome[OUT_HALT] || rsp_outcome[OUT_PERF])); // R7

    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_outcome[OUT_TRAP2] || rsp_outcome[OUT_TRAP3])) |-> rsp_class == TRAP_CLASS); // R8

    AST_NOTRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        (rsp_outcome[OUT_PERF] || rsp_outcome[OUT_UNDEF] || rsp_outcome[OUT_HALT]) |-> rsp_class == '0); // R8

    AST_EARLY_WINS_L1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_level == 2'd1 && halted && has_l3 && sec_dbg_off && l3_prio_opt && mon_trap)
        |=> rsp_outcome[OUT_UNDEF]); // R2
endmodule

// File: tb/tb_dbg_access_gate.sv
module tb_dbg_access_gate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0;
    logic [1:0] cur_level = 0;
    logic has_l3 = 0, l2_active = 0, halted = 0, sec_dbg_off = 0, l3_prio_opt = 0;
    logic mon_trap = 0, l3_fg_en = 0, fg_rd_trap = 0, fg_wr_trap = 0;
    logic hyp_trap_all = 0, hyp_trap_dbg = 0, os_lock = 0, halt_ok = 0, ext_trap = 0;
    logic       rsp_valid;
    logic [4:0] rsp_outcome;
    logic [5:0] rsp_class;

    always #10 clk = ~clk;

    dbg_access_gate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .cur_level(cur_level), .has_l3(has_l3), .l2_active(l2_active),
        .halted(halted), .sec_dbg_off(sec_dbg_off), .l3_prio_opt(l3_prio_opt),
        .mon_trap(mon_trap), .l3_fg_en(l3_fg_en), .fg_rd_trap(fg_rd_trap),
        .fg_wr_trap(fg_wr_trap), .hyp_trap_all(hyp_trap_all),
        .hyp_trap_dbg(hyp_trap_dbg), .os_lock(os_lock), .halt_ok(halt_ok),
        .ext_trap(ext_trap), .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_class(rsp_class)
    );

    // outcome codes from R9
    localparam logic [4:0] E_PERF = 5'b00001, E_UNDEF = 5'b00010,
                           E_TRAP2 = 5'b00100, E_TRAP3 = 5'b01000, E_HALT = 5'b10000;

    typedef struct {
        logic [4:0] outc;
        logic [5:0] cls;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // reference decision written from the requirement list
    function automatic exp_t model(input logic [17:0] v);
        exp_t e;
        logic wr, l3, l2, hl, sd, po, mt, fe, fr, fw, ta, td, ol, hk, et;
        logic [1:0] lv;
        {wr, lv, l3, l2, hl, sd, po, mt, fe, fr, fw, ta, td, ol, hk, et} = v[17:0];
        e.tag = "";
        if (lv == 2'd0) begin e.outc = E_UNDEF; e.tag = "R1"; end
        else if (lv == 2'd1 && hl && l3 && sd && po && mt) begin e.outc = E_UNDEF; e.tag = "R2"; end
        else if (lv == 2'd1 && l2 && (!l3 || fe) && (wr ? fw : fr)) begin e.outc = E_TRAP2; e.tag = "R3"; end
        else if (lv == 2'd1 && l2 && (ta || td)) begin e.outc = E_TRAP2; e.tag = "R4"; end
        else if (lv != 2'd3 && l3 && mt) begin e.outc = (hl && sd) ? E_UNDEF : E_TRAP3; e.tag = "R5"; end
        else if (!ol && hk && et) begin e.outc = E_HALT; e.tag = "R6"; end
        else begin e.outc = E_PERF; e.tag = (lv == 2'd3) ? "R7" : "R6"; end
        e.cls = (e.outc == E_TRAP2 || e.outc == E_TRAP3) ? 6'h18 : 6'h00;
        return e;
    endfunction

    task automatic send(input logic [17:0] v);
        exp_t e;
        @(negedge clk);
        {req_write, cur_level, has_l3, l2_active, halted, sec_dbg_off, l3_prio_opt,
         mon_trap, l3_fg_en, fg_rd_trap, fg_wr_trap, hyp_trap_all, hyp_trap_dbg,
         os_lock, halt_ok, ext_trap} = v;
        req_valid = 1'b1;
        e = model(v);
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // field order: wr lv[2] l3 l2 hl sd po mt fe fr fw ta td ol hk et
    function automatic logic [17:0] mk(input logic wr, input logic [1:0] lv,
        input logic l3, input logic l2, input logic hl, input logic sd, input logic po,
        input logic mt, input logic fe, input logic fr, input logic fw, input logic ta,
        input logic td, input logic ol, input logic hk, input logic et);
        return {wr, lv, l3, l2, hl, sd, po, mt, fe, fr, fw, ta, td, ol, hk, et};
    endfunction

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " R9 outcome"}, {27'd0, rsp_outcome}, {27'd0, e.outc});
                    check("R8 class", {26'd0, rsp_class}, {26'd0, e.cls});
                end
            end else if (!rst) begin
                // R10: quiet when nothing is answered
                if (rsp_outcome !== 5'd0 || rsp_class !== 6'd0)
                    check("R10 idle outputs", {21'd0, rsp_outcome, rsp_class}, 0);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset valid", {31'd0, rsp_valid}, 0);
        check("R10 reset outcome", {27'd0, rsp_outcome}, 0);
        check("R10 reset class", {26'd0, rsp_class}, 0);

        // R1: level 0 even with everything quiet or everything set
        send(mk(0,0, 0,0,0,0,0,0,0,0,0,0,0,0,0,0));
        send(mk(1,0, 1,1,1,1,1,1,1,1,1,1,1,0,1,1));
        // R2: early undefined beats fine-grained and hypervisor traps
        send(mk(0,1, 1,1,1,1,1,1,1,1,1,1,1,0,1,1));
        // R2 missing priority option: falls to fine-grained (R3)
        send(mk(0,1, 1,1,1,1,0,1,1,1,1,1,1,0,1,1));
        // R3: read uses read bit only; write bit ignored on read
        send(mk(0,1, 0,1,0,0,0,0,0,0,1,0,0,1,0,0));
        send(mk(1,1, 0,1,0,0,0,0,0,0,1,0,0,1,0,0));
        send(mk(1,1, 0,1,0,0,0,0,0,1,0,0,0,1,0,0));
        // R3: blocked by level 3 without fine-grained enable
        send(mk(0,1, 1,1,0,0,0,0,0,1,0,0,0,1,0,0));
        send(mk(0,1, 1,1,0,0,0,0,1,1,0,0,0,1,0,0));
        // R4: each hypervisor bit, and with level 2 off
        send(mk(0,1, 0,1,0,0,0,0,0,0,0,1,0,1,0,0));
        send(mk(0,1, 0,1,0,0,0,0,0,0,0,0,1,1,0,0));
        send(mk(0,1, 0,0,0,0,0,0,0,0,0,1,1,1,0,0));
        idle(2);
        // R5: monitor trap at levels 1 and 2, halted-secure gives undefined
        send(mk(0,1, 1,0,0,0,0,1,0,0,0,0,0,1,0,0));
        send(mk(0,2, 1,1,1,1,0,1,0,0,0,0,0,1,0,0));
        send(mk(0,2, 1,1,1,0,0,1,0,0,0,0,0,1,0,0));
        // R6: halt vs lock
        send(mk(0,2, 0,0,0,0,0,0,0,0,0,0,0,0,1,1));
        send(mk(0,2, 0,0,0,0,0,0,0,0,0,0,0,1,1,1));
        // R7: level 2 ignores level-2 traps; level 3 ignores monitor
        send(mk(1,2, 0,1,0,0,0,0,1,1,1,1,1,1,0,0));
        send(mk(1,3, 1,1,1,1,1,1,1,1,1,1,1,1,0,0));
        send(mk(0,3, 1,1,1,1,1,1,1,1,1,1,1,0,1,1));
        idle(3);
        // pseudo-random sweep, mixing back-to-back and gaps
        for (int i = 0; i < 4000; i++) begin
            send(18'($urandom));
            if (($urandom % 4) == 0) idle(1);
        end
        idle(3);
        check("R10 all responses seen", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule